// File: doc/BRIEF.md
# Block-Ack Window Tracker

This block keeps the delivery scoreboard for one traffic stream. The stream is one receiver address and traffic identifier pair. The block tracks a sliding window of at most 64 consecutive 12-bit sequence numbers. For each slot it holds two status bits: the frame was sent, and the frame was acknowledged.

The transmit path reports each frame it sends. The block accepts or refuses that event in the same cycle, so frames never run ahead of the window or past the outstanding-frame budget. Block-ack reports arrive as a start sequence number and a 64-bit bitmap. The block applies each report in a single cycle, with no software involved. It then does three things:
- It reports how many frames the report newly completed, in whatever order they were acknowledged.
- It moves the window base past the acknowledged frames at the head of the window.
- It queues retransmit requests for sent frames that the report shows as missing.

Fragmented frames are not handled.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset the window base is 0, the outstanding count is 0, and neither `retry_valid` nor `comp_valid` is asserted.
- R2: A send event is accepted only when (send_seq - win_base) mod 4096 is less than the effective window size. The effective window size is `cfg_win_size`, limited to 64. A refused event changes no state.
- R3: A send for a sequence number not yet sent is refused when the outstanding count has reached the effective frame limit. The outstanding count is the number of frames sent but not acknowledged. The effective frame limit is `cfg_frame_limit`, limited to 64. A resend of a frame that is sent but unacknowledged is accepted and does not raise the count.
- R4: Bit i of `ba_bitmap` refers to sequence number (ba_start + i) mod 4096. Bits that point at frames outside the window, or at frames not yet sent, are ignored.
- R5: After a report, the window base moves past every acknowledged frame that forms an unbroken run from the base. Those slots are freed.
- R6: `comp_valid` pulses in the cycle after every report. With it, `comp_count` gives the number of frames that the report newly acknowledged, including frames acknowledged out of order behind an unacknowledged one.
- R7: When a report covers a frame that is sent but unacknowledged and its bit is 0, a retransmit request is queued for that frame. The block presents queued requests lowest window offset first on `retry_valid`/`retry_seq`. Each request is held until `retry_ready` is high at a clock edge.
- R8: An `init_valid` pulse loads `init_seq` as the window base and clears all slot state, queued retransmits and outstanding frames.
- R9: All sequence comparisons and window positions wrap modulo 4096.
- R10: A frame that is acknowledged while its retransmit request is still queued has that request withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_size | input | 7 | Window size, values above 64 act as 64 |
| cfg_frame_limit | input | 7 | Maximum outstanding frames, values above 64 act as 64 |
| init_valid | input | 1 | Load a new window base and clear state |
| init_seq | input | 12 | New window base |
| send_valid | input | 1 | A frame is being sent |
| send_seq | input | 12 | Sequence number of the sent frame |
| send_accept | output | 1 | Send event accepted (combinational) |
| ba_valid | input | 1 | Block-ack report present |
| ba_start | input | 12 | Sequence number of bitmap bit 0 |
| ba_bitmap | input | 64 | Acknowledge bits |
| retry_valid | output | 1 | A retransmit request is pending |
| retry_seq | output | 12 | Sequence number to retransmit |
| retry_ready | input | 1 | Consumer takes the request |
| comp_valid | output | 1 | Pulse after each report |
| comp_count | output | 7 | Frames newly acknowledged by that report |
| win_base | output | 12 | Current window start |
| outstanding | output | 7 | Frames sent and not yet acknowledged |

## Verification
The assertions hold on every cycle for the following:
- the base never jumps by more than a full window;
- the outstanding count never grows by more than one per cycle;
- a pending retransmit request stays stable until it is taken;
- completion pulses only follow reports;
- an init leaves nothing pending.

Only the bench scenarios can show the ordering and content of the retransmit requests, the out-of-order completion counts, window wrap through 4095, and that stray bitmap bits are ignored.

// File: rtl/ba_window_tracker.sv
module ba_window_tracker #(
  parameter int SEQ_W = 12,
  parameter int WIN   = 64,
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_win_size,
  input  logic [CFG_W-1:0] cfg_frame_limit,
  input  logic             init_valid,
  input  logic [SEQ_W-1:0] init_seq,
  input  logic             send_valid,
  input  logic [SEQ_W-1:0] send_seq,
  output logic             send_accept,
  input  logic             ba_valid,
  input  logic [SEQ_W-1:0] ba_start,
  input  logic [WIN-1:0]   ba_bitmap,
  output logic             retry_valid,
  output logic [SEQ_W-1:0] retry_seq,
  input  logic             retry_ready,
  output logic             comp_valid,
  output logic [CFG_W-1:0] comp_count,
  output logic [SEQ_W-1:0] win_base,
  output logic [CFG_W-1:0] outstanding
);
  localparam int SLOT_W = $clog2(WIN);
  localparam logic [CFG_W-1:0] WMAX = CFG_W'(WIN);

  logic [WIN-1:0]   sent_q, ack_q, retry_q;
  logic [SEQ_W-1:0] base_q;
  logic             comp_q;
  logic [CFG_W-1:0] comp_cnt_q;

  logic [CFG_W-1:0] wsz, flim, outst, new_cnt;
  logic [WIN-1:0]   ack_new, miss, ack_nx, clr, fire_mask, send_mask;
  logic [SEQ_W-1:0] pick_seq;
  logic             pick_any;

  assign wsz  = (cfg_win_size    > WMAX) ? WMAX : cfg_win_size;
  assign flim = (cfg_frame_limit > WMAX) ? WMAX : cfg_frame_limit;

  // per-slot report decode; slot index is seq mod WIN
  always_comb begin
    ack_new = '0;
    miss    = '0;
    for (int j = 0; j < WIN; j++) begin
      logic [SLOT_W-1:0] k;
      logic [SEQ_W-1:0]  sq, bi;
      logic              cov, bitv, hit;
      k    = SLOT_W'(j) - base_q[SLOT_W-1:0];
      sq   = base_q + SEQ_W'(k);
      bi   = sq - ba_start;
      cov  = bi < SEQ_W'(WIN);
      bitv = cov && ba_bitmap[bi[SLOT_W-1:0]];
      hit  = ba_valid && (CFG_W'(k) < wsz) && sent_q[j] && cov && !ack_q[j];
      ack_new[j] = hit && bitv;
      miss[j]    = hit && !bitv;
    end
  end

  assign ack_nx = ack_q | ack_new;

  // leading acknowledged run from the base
  logic [SEQ_W-1:0] adv;
  always_comb begin
    logic run;
    run = 1'b1;
    adv = '0;
    clr = '0;
    for (int k = 0; k < WIN; k++) begin
      logic [SLOT_W-1:0] j;
      j = base_q[SLOT_W-1:0] + SLOT_W'(k);
      if (run && (CFG_W'(k) < wsz) && ack_nx[j]) begin
        clr[j] = 1'b1;
        adv    = adv + 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end

  always_comb begin
    outst   = '0;
    new_cnt = '0;
    for (int j = 0; j < WIN; j++) begin
      outst   = outst   + CFG_W'(sent_q[j] & ~ack_q[j]);
      new_cnt = new_cnt + CFG_W'(ack_new[j]);
    end
  end

  // send admission
  logic [SEQ_W-1:0]  soff;
  logic [SLOT_W-1:0] sslot;
  logic              s_resend, s_fresh;
  assign soff     = send_seq - base_q;
  assign sslot    = send_seq[SLOT_W-1:0];
  assign s_resend = sent_q[sslot] && !ack_q[sslot];
  assign s_fresh  = !sent_q[sslot];
  assign send_accept = send_valid && !init_valid && (soff < SEQ_W'(wsz)) &&
                       (s_resend || (s_fresh && outst < flim));
  assign send_mask = send_accept ? (WIN'(1) << sslot) : '0;

  // oldest pending retransmit
  always_comb begin
    pick_any  = 1'b0;
    pick_seq  = base_q;
    fire_mask = '0;
    for (int k = 0; k < WIN; k++) begin
      logic [SLOT_W-1:0] j;
      j = base_q[SLOT_W-1:0] + SLOT_W'(k);
      if (!pick_any && retry_q[j]) begin
        pick_any     = 1'b1;
        pick_seq     = base_q + SEQ_W'(k);
        fire_mask[j] = retry_ready;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_q <= '0; ack_q <= '0; retry_q <= '0;
      base_q <= '0; comp_q <= 1'b0; comp_cnt_q <= '0;
    end else if (init_valid) begin
      sent_q <= '0; ack_q <= '0; retry_q <= '0;
      base_q <= init_seq; comp_q <= 1'b0; comp_cnt_q <= '0;
    end else begin
      sent_q     <= (sent_q | send_mask) & ~clr;
      ack_q      <= ack_nx & ~clr;
      retry_q    <= ((retry_q & ~fire_mask) | miss) & ~ack_new & ~clr;
      base_q     <= base_q + adv;
      comp_q     <= ba_valid;
      comp_cnt_q <= ba_valid ? new_cnt : '0;
    end
  end

  assign retry_valid = pick_any;
  assign retry_seq   = pick_seq;
  assign comp_valid  = comp_q;
  assign comp_count  = comp_cnt_q;
  assign win_base    = base_q;
  assign outstanding = outst;

  a_r5_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_valid) |-> (SEQ_W'(win_base - $past(win_base)) <= SEQ_W'(WIN)));
  a_r3_outstanding_step: assert property (@(posedge clk) disable iff (!rst_n)
    !init_valid |=> (outstanding <= $past(outstanding) + CFG_W'(1)));
  a_r7_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_valid && !retry_ready && !ba_valid && !init_valid) |=>
      (retry_valid && $stable(retry_seq)));
  a_r6_comp_after_report: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_valid) |-> $past(ba_valid));
  a_r8_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |=> (!retry_valid && outstanding == '0 && !comp_valid));
endmodule

// File: tb/sim_ba_window_tracker.sv
module sim_ba_window_tracker;
  logic clk = 0, rst_n = 0;
  logic [6:0] cfg_win_size = 7'd64, cfg_frame_limit = 7'd64;
  logic init_valid = 0, send_valid = 0, ba_valid = 0, retry_ready = 0;
  logic [11:0] init_seq = 0, send_seq = 0, ba_start = 0;
  logic [63:0] ba_bitmap = 0;
  logic send_accept, retry_valid, comp_valid;
  logic [11:0] retry_seq, win_base;
  logic [6:0] comp_count, outstanding;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [11:0] exp_q[$];

  always #5 clk = ~clk;

  ba_window_tracker u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic send(logic [11:0] s, bit exp, string req);
    send_valid = 1; send_seq = s; #1;
    chk(req, send_accept, exp);
    tick(); send_valid = 0;
  endtask

  task automatic report(logic [11:0] st, logic [63:0] bm, int cnt, string req);
    ba_valid = 1; ba_start = st; ba_bitmap = bm;
    tick(); ba_valid = 0;
    chk(req, comp_valid, 1);
    chk(req, comp_count, cnt);
  endtask

  always @(negedge clk) if (rst_n && retry_valid && retry_ready) begin
    if (exp_q.size() == 0) chk("R7 unexpected retry", retry_seq, -1);
    else chk("R7 retry order", retry_seq, exp_q.pop_front());
  end

  initial begin
    #(200000*10);
    chk("watchdog", 0, 1);
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2 rst_n = 1;
    chk("R1 base", win_base, 0);
    chk("R1 outstanding", outstanding, 0);
    chk("R1 retry", retry_valid, 0);
    chk("R1 comp", comp_valid, 0);
    // R8 R9: start near the wrap point
    init_valid = 1; init_seq = 12'd4090; tick(); init_valid = 0;
    chk("R8 base load", win_base, 4090);
    for (int i = 0; i < 10; i++) send(12'((4090 + i) % 4096), 1, "R2 R9 in-window send");
    send(12'd58, 0, "R2 offset 64 refused");
    chk("R2 outstanding", outstanding, 10);
    // report: 4090,4091,4093 acked, bit 20 (seq 14, unsent) ignored
    report(12'd4090, 64'h0010_000B, 3, "R6 R4 report 1");
    chk("R5 base advance", win_base, 4092);
    chk("R7 retry head", retry_valid, 1);
    chk("R7 retry head seq", retry_seq, 4092);
    tick();
    chk("R7 retry held", retry_seq, 4092);
    // ack 4094 out of order; withdraws its retry
    report(12'd4094, 64'h1, 1, "R6 R10 report 2");
    chk("R5 base stays", win_base, 4092);
    exp_q = '{12'd4092, 12'd4095, 12'd0, 12'd1, 12'd2, 12'd3};
    retry_ready = 1;
    repeat (6) @(posedge clk);
    #2 retry_ready = 0;
    chk("R7 retries drained", retry_valid, 0);
    chk("R7 queue empty", exp_q.size(), 0);
    // complete the rest out of order
    report(12'd4092, 64'hFF, 6, "R6 report 3");
    chk("R5 R9 base wraps", win_base, 4);
    chk("R5 outstanding", outstanding, 0);
    // R3 frame limit
    cfg_frame_limit = 7'd2;
    send(12'd4, 1, "R3 first");
    send(12'd5, 1, "R3 second");
    send(12'd6, 0, "R3 limit refuse");
    send(12'd4, 1, "R3 resend ok");
    chk("R3 count", outstanding, 2);
    // R2 window size and clamp
    cfg_frame_limit = 7'd64; cfg_win_size = 7'd3;
    send(12'd6, 1, "R2 offset 2");
    send(12'd7, 0, "R2 offset 3 refused");
    cfg_win_size = 7'd100;
    send(12'd68, 0, "R2 clamp offset 64");
    send(12'd67, 1, "R2 clamp offset 63");
    // R4 ignored bits
    report(12'd100, '1, 0, "R4 out of window");
    chk("R4 base", win_base, 4);
    chk("R4 outstanding", outstanding, 4);
    chk("R4 no retry", retry_valid, 0);
    report(12'd10, 64'h1, 0, "R4 unsent");
    chk("R4 outstanding 2", outstanding, 4);
    // R8 re-init
    init_valid = 1; init_seq = 12'd0; tick(); init_valid = 0;
    chk("R8 base", win_base, 0);
    chk("R8 cleared", outstanding, 0);
    chk("R8 no retry", retry_valid, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule